// File: doc/BRIEF.md
# Variable-Length Streaming Frame Sequencer

This block feeds a valid/ready streaming sink, such as a transform engine whose length can change, with framed sample streams. An upstream producer offers samples one at a time with a handshake and a size code. The sequencer cuts those samples into frames whose length is a power of two, chosen per frame. Each sample passes through one output register. The sequencer marks the first and last sample of every frame, leaves one idle cycle after each frame, and keeps the frame size steady on its output from the first sample to the last.

The sink may drop ready at any time. A common case is the long drain it performs after it sees a new frame size. During that time the sequencer freezes its output register and takes nothing from upstream. A stall watchdog raises a flag when ready has been withheld from a presented sample for a parameterised number of consecutive cycles.

The control path is a four-state machine:
- ST_IDLE: no sample is held. The sequencer waits for the first sample of a frame.
- ST_HEAD: the start sample is loaded.
- ST_BODY: the middle samples are loaded.
- ST_TAIL: the end sample waits for acceptance.

The transitions are:
- ST_IDLE to ST_HEAD, on the first upstream transfer.
- ST_HEAD or ST_BODY to ST_BODY, on a transfer that is not the last sample.
- ST_HEAD or ST_BODY to ST_TAIL, on the transfer of the last sample.
- ST_TAIL to ST_IDLE, when the sink accepts the end sample.

Top module: `frame_seq`

## Requirements
- R1: dn_sop is high on exactly the first transferred sample of a frame, and dn_eop on exactly the last. A frame with size code k carries exactly 2^(3+k) transfers, where a transfer is a cycle with dn_valid and dn_ready both high.
- R2: While dn_valid is high and dn_ready is low, dn_valid, dn_data, dn_sop, dn_eop and dn_size keep their values into the next cycle, and up_ready is low.
- R3: In the cycle after an end-of-frame transfer, dn_valid is low. If upstream has data waiting, the next frame's start sample is transferred two cycles after the end sample.
- R4: dn_size is taken from up_size on the first sample of a frame and stays fixed until that frame's last sample. up_size values offered with later samples have no effect.
- R5: Size codes 0, 1, 2 and 3 give frames of 8, 16, 32 and 64 samples.
- R6: dn_err is always 2'b00.
- R7: When the sink withholds ready from a new frame's start sample for hundreds of cycles, the start sample stays presented with its size. The frame then continues intact when ready returns.
- R8: stall_timeout goes high after TIMEOUT_CYC consecutive cycles in which dn_valid is high and dn_ready is low. It is low again in the cycle after a transfer.
- R9: A synchronous active-high reset leaves dn_valid low, up_ready high, stall_timeout low and the machine in ST_IDLE.
- R10: A sample moves from upstream only when up_valid and up_ready are both high. up_ready is low while the end sample of a frame is held. Upstream gaps inside a frame make dn_valid bubbles without ending the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream sample offered |
| up_ready | output | 1 | Sequencer can take a sample |
| up_data | input | DATA_W | Upstream sample |
| up_size | input | SIZE_W | Size code requested for a frame (used on its first sample) |
| dn_valid | output | 1 | Output sample valid |
| dn_ready | input | 1 | Sink accepts the sample |
| dn_data | output | DATA_W | Output sample |
| dn_sop | output | 1 | First sample of a frame |
| dn_eop | output | 1 | Last sample of a frame |
| dn_err | output | 2 | Error field, always zero |
| dn_size | output | SIZE_W | Size code of the current frame |
| stall_timeout | output | 1 | Ready withheld for TIMEOUT_CYC cycles |

## Verification
The assertions check these on every cycle:
- the frame markers against a running beat count, including the exact length implied by dn_size;
- the freeze of all output fields during a stall, and the closed upstream port during a stall;
- the single idle cycle after each end sample;
- the constancy of dn_size across a frame;
- the blocked intake while an end sample is held.

Only the directed scenarios can show:
- that samples arrive in order with the right data;
- that a mid-frame change of up_size is ignored;
- the exact cycle count from one end sample to the next start sample;
- that a drain of hundreds of cycles ends with an intact frame;
- the exact cycles at which the watchdog flag rises and falls.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2,
        ST_TAIL = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
#(
    parameter int SIZE_W   = 2,
    parameter int MIN_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    input  logic [SIZE_W-1:0] up_size,
    input  logic              out_valid,
    input  logic              dn_ready,
    output logic              up_ready,
    output logic              load,
    output logic              load_sop,
    output logic              load_eop,
    output logic [SIZE_W-1:0] load_size
);

    localparam int CNT_W = MIN_LOG2 + (1 << SIZE_W);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [SIZE_W-1:0] size_q;
    logic [CNT_W-1:0]  last_idx;
    logic              slot_free;
    logic              at_last;

    // The output register can take a sample when it is empty or is being emptied.
    assign slot_free = !out_valid || dn_ready;

    // Index of the last sample in a frame of the latched size.
    always_comb begin
        last_idx = (CNT_W'(1) << (MIN_LOG2 + int'(size_q))) - CNT_W'(1);
    end

    assign at_last = (cnt_q == last_idx);
    assign load    = up_valid && up_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (up_valid) begin
                    state_d = ST_HEAD;
                end
            end
            ST_HEAD, ST_BODY: begin
                if (load) begin
                    state_d = at_last ? ST_TAIL : ST_BODY;
                end
            end
            ST_TAIL: begin
                if (dn_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        up_ready  = 1'b0;
        load_sop  = 1'b0;
        load_eop  = 1'b0;
        load_size = size_q;
        unique case (state_q)
            ST_IDLE: begin
                up_ready  = 1'b1;
                load_sop  = 1'b1;
                load_size = up_size;
            end
            ST_HEAD, ST_BODY: begin
                up_ready = slot_free;
                load_eop = at_last;
            end
            ST_TAIL: begin
                up_ready = 1'b0;
            end
            default: begin
                up_ready = 1'b0;
            end
        endcase
    end

    // Sample count and latched frame size
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            size_q <= '0;
        end else if (load) begin
            if (state_q == ST_IDLE) begin
                cnt_q  <= CNT_W'(1);
                size_q <= up_size;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/fseq_outreg.sv
module fseq_outreg #(
    parameter int DATA_W = 16,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_sop,
    input  logic              load_eop,
    input  logic [SIZE_W-1:0] load_size,
    input  logic [DATA_W-1:0] load_data,
    input  logic              dn_ready,
    output logic              dn_valid,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_sop,
    output logic              dn_eop,
    output logic [SIZE_W-1:0] dn_size
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_sop   <= 1'b0;
            dn_eop   <= 1'b0;
            dn_data  <= '0;
            dn_size  <= '0;
        end else if (load) begin
            dn_valid <= 1'b1;
            dn_sop   <= load_sop;
            dn_eop   <= load_eop;
            dn_data  <= load_data;
            dn_size  <= load_size;
        end else if (dn_ready) begin
            dn_valid <= 1'b0;
            dn_sop   <= 1'b0;
            dn_eop   <= 1'b0;
        end
    end

endmodule

// File: rtl/fseq_stall_wd.sv
module fseq_stall_wd #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic dn_valid,
    input  logic dn_ready,
    output logic timeout
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (dn_valid && !dn_ready) begin
            if (cnt_q != CW'(LIMIT)) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign timeout = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
    parameter int DATA_W      = 16,
    parameter int SIZE_W      = 2,
    parameter int MIN_LOG2    = 3,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    input  logic [SIZE_W-1:0] up_size,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data,
    output logic              dn_sop,
    output logic              dn_eop,
    output logic [1:0]        dn_err,
    output logic [SIZE_W-1:0] dn_size,
    output logic              stall_timeout
);

    logic              load;
    logic              load_sop;
    logic              load_eop;
    logic [SIZE_W-1:0] load_size;

    fseq_ctrl #(
        .SIZE_W   (SIZE_W),
        .MIN_LOG2 (MIN_LOG2)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .up_valid  (up_valid),
        .up_size   (up_size),
        .out_valid (dn_valid),
        .dn_ready  (dn_ready),
        .up_ready  (up_ready),
        .load      (load),
        .load_sop  (load_sop),
        .load_eop  (load_eop),
        .load_size (load_size)
    );

    fseq_outreg #(
        .DATA_W (DATA_W),
        .SIZE_W (SIZE_W)
    ) u_outreg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_sop  (load_sop),
        .load_eop  (load_eop),
        .load_size (load_size),
        .load_data (up_data),
        .dn_ready  (dn_ready),
        .dn_valid  (dn_valid),
        .dn_data   (dn_data),
        .dn_sop    (dn_sop),
        .dn_eop    (dn_eop),
        .dn_size   (dn_size)
    );

    fseq_stall_wd #(
        .LIMIT (TIMEOUT_CYC)
    ) u_wd (
        .clk      (clk),
        .rst      (rst),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .timeout  (stall_timeout)
    );

    assign dn_err = 2'b00;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int DATA_W   = 16,
    parameter int SIZE_W   = 2,
    parameter int MIN_LOG2 = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              up_ready,
    input logic              dn_valid,
    input logic              dn_ready,
    input logic [DATA_W-1:0] dn_data,
    input logic              dn_sop,
    input logic              dn_eop,
    input logic [SIZE_W-1:0] dn_size
);

    localparam int CNT_W = MIN_LOG2 + (1 << SIZE_W);

    logic [CNT_W-1:0]  beat_q;
    logic              in_frame_q;
    logic [SIZE_W-1:0] frm_size_q;
    logic [CNT_W-1:0]  exp_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q     <= '0;
            in_frame_q <= 1'b0;
            frm_size_q <= '0;
        end else if (dn_valid && dn_ready) begin
            if (dn_sop) begin
                frm_size_q <= dn_size;
            end
            if (dn_eop) begin
                beat_q     <= '0;
                in_frame_q <= 1'b0;
            end else begin
                beat_q     <= beat_q + CNT_W'(1);
                in_frame_q <= 1'b1;
            end
        end
    end

    always_comb begin
        exp_last = (CNT_W'(1) << (MIN_LOG2 + int'(dn_size))) - CNT_W'(1);
    end

    // R1: a start marker only opens a new frame
    a_r1_sop_opens: assert property (@(posedge clk) disable iff (rst)
        dn_valid && dn_sop |-> !in_frame_q && beat_q == '0);

    // R1: samples without a start marker belong to an open frame
    a_r1_body_in_frame: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_sop |-> in_frame_q);

    // R1, R5: the end marker falls on the last beat for the size code
    a_r1_eop_length: assert property (@(posedge clk) disable iff (rst)
        dn_valid && dn_eop |-> beat_q == exp_last);

    // R2: a stalled sample is frozen
    a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data) && $stable(dn_sop)
                                  && $stable(dn_eop) && $stable(dn_size));

    // R2: no intake while stalled
    a_r2_no_intake: assert property (@(posedge clk) disable iff (rst)
        dn_valid && !dn_ready |-> !up_ready);

    // R3: idle cycle after each end sample
    a_r3_gap_after_eop: assert property (@(posedge clk) disable iff (rst)
        dn_valid && dn_ready && dn_eop |=> !dn_valid);

    // R4: size constant within a frame
    a_r4_size_fixed: assert property (@(posedge clk) disable iff (rst)
        dn_valid && in_frame_q |-> dn_size == frm_size_q);

    // R10: intake closed while the end sample is held
    a_r10_tail_closed: assert property (@(posedge clk) disable iff (rst)
        dn_valid && dn_eop |-> !up_ready);

endmodule

bind frame_seq frame_seq_chk #(
    .DATA_W   (DATA_W),
    .SIZE_W   (SIZE_W),
    .MIN_LOG2 (MIN_LOG2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_ready (up_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_data  (dn_data),
    .dn_sop   (dn_sop),
    .dn_eop   (dn_eop),
    .dn_size  (dn_size)
);

// File: tb/frame_seq_bench.sv
`timescale 1ns/1ps
module frame_seq_bench;

    localparam int DW = 16;
    localparam int SW = 2;
    localparam int TO = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_valid = 1'b0;
    logic          up_ready;
    logic [DW-1:0] up_data = '0;
    logic [SW-1:0] up_size = '0;
    logic          dn_valid;
    logic          dn_ready = 1'b0;
    logic [DW-1:0] dn_data;
    logic          dn_sop;
    logic          dn_eop;
    logic [1:0]    dn_err;
    logic [SW-1:0] dn_size;
    logic          stall_timeout;

    always #2 clk = ~clk;

    frame_seq #(
        .DATA_W      (DW),
        .SIZE_W      (SW),
        .MIN_LOG2    (3),
        .TIMEOUT_CYC (TO)
    ) u_frame_seq (
        .clk           (clk),
        .rst           (rst),
        .up_valid      (up_valid),
        .up_ready      (up_ready),
        .up_data       (up_data),
        .up_size       (up_size),
        .dn_valid      (dn_valid),
        .dn_ready      (dn_ready),
        .dn_data       (dn_data),
        .dn_sop        (dn_sop),
        .dn_eop        (dn_eop),
        .dn_err        (dn_err),
        .dn_size       (dn_size),
        .stall_timeout (stall_timeout)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always @(posedge clk) cyc++;

    // Sink model, transfer log and stall-hold monitor
    int            sink_mode = 0;
    int            drain_left = 0;
    logic [15:0]   lfsr = 16'hACE1;
    int            nlog = 0;
    logic [DW-1:0] log_data [0:1023];
    logic          log_sop  [0:1023];
    logic          log_eop  [0:1023];
    logic [SW-1:0] log_size [0:1023];
    logic [1:0]    log_err  [0:1023];
    int            log_cyc  [0:1023];
    bit            prev_stall = 0;
    logic [DW-1:0] p_data;
    logic          p_sop, p_eop;
    logic [SW-1:0] p_size;
    int            hold_bad = 0;
    bit            saw_to = 0;

    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (sink_mode)
            0: dn_ready = 1'b1;
            1: dn_ready = lfsr[0] | lfsr[3];
            2: dn_ready = 1'b0;
            default: begin
                if (dn_valid && dn_sop && drain_left > 0) begin
                    dn_ready = 1'b0;
                    drain_left--;
                end else begin
                    dn_ready = 1'b1;
                end
            end
        endcase
        if (!rst && prev_stall &&
            (dn_valid !== 1'b1 || dn_data !== p_data || dn_sop !== p_sop ||
             dn_eop !== p_eop || dn_size !== p_size)) begin
            hold_bad++;
        end
        prev_stall = !rst && dn_valid && !dn_ready;
        p_data = dn_data; p_sop = dn_sop; p_eop = dn_eop; p_size = dn_size;
        if (stall_timeout === 1'b1) saw_to = 1;
        if (!rst && dn_valid && dn_ready && nlog < 1024) begin
            log_data[nlog] = dn_data;
            log_sop[nlog]  = dn_sop;
            log_eop[nlog]  = dn_eop;
            log_size[nlog] = dn_size;
            log_err[nlog]  = dn_err;
            log_cyc[nlog]  = cyc;
            nlog++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int frame_len(input int code);
        return 8 << code;
    endfunction

    task automatic send_frame(input int code, input int base, input bit bubbles,
                              input bit mid_change);
        for (int i = 0; i < frame_len(code); i++) begin
            if (bubbles && (i % 3 == 1)) begin
                @(negedge clk);
                up_valid = 1'b0;
            end
            do begin
                @(negedge clk);
                up_valid = 1'b1;
                up_data  = DW'(base + i);
                up_size  = (i == 0 || !mid_change) ? SW'(code) : ~SW'(code);
                #1;
            end while (!up_ready);
        end
    endtask

    task automatic up_end();
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic wait_log(input int n);
        while (nlog < n) @(negedge clk);
    endtask

    task automatic check_frame(input int start, input int code, input int base,
                               input string req);
        int len = frame_len(code);
        int dbad = 0, mbad = 0, sbad = 0, ebad = 0, first_bad = -1;
        for (int i = 0; i < len; i++) begin
            if (log_data[start+i] !== DW'(base + i)) begin
                dbad++;
                if (first_bad < 0) first_bad = i;
            end
            if (log_sop[start+i] !== (i == 0) || log_eop[start+i] !== (i == len - 1)) mbad++;
            if (log_size[start+i] !== SW'(code)) sbad++;
            if (log_err[start+i] !== 2'b00) ebad++;
        end
        chk(dbad == 0, req, "sample data mismatches", dbad, 0);
        chk(mbad == 0, "R1", "misplaced sop/eop markers", mbad, 0);
        chk(sbad == 0, "R4", "size code changed in frame", sbad, 0);
        chk(ebad == 0, "R6", "nonzero error field", ebad, 0);
    endtask

    // R9, R6: state after reset
    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dn_valid === 1'b0, "R9", "dn_valid after reset", int'(dn_valid), 0);
        chk(up_ready === 1'b1, "R9", "up_ready after reset", int'(up_ready), 1);
        chk(stall_timeout === 1'b0, "R9", "stall_timeout after reset", int'(stall_timeout), 0);
        chk(dn_err === 2'b00, "R6", "dn_err after reset", int'(dn_err), 0);
    endtask

    // R1, R3, R5: every size back to back with the sink always ready
    task automatic t_all_sizes();
        int start = nlog;
        int idx;
        sink_mode = 0;
        send_frame(0, 16'h0100, 0, 0);
        send_frame(1, 16'h0200, 0, 0);
        send_frame(2, 16'h0300, 0, 0);
        send_frame(3, 16'h0400, 0, 0);
        up_end();
        wait_log(start + 8 + 16 + 32 + 64);
        idx = start;
        for (int c = 0; c < 4; c++) begin
            check_frame(idx, c, 16'h0100 * (c + 1), "R5");
            if (c > 0) begin
                chk(log_cyc[idx] - log_cyc[idx-1] == 2, "R3", "cycles eop to next sop",
                    log_cyc[idx] - log_cyc[idx-1], 2);
            end
            idx += frame_len(c);
        end
    endtask

    // R2, R4, R10: random sink stalls, upstream bubbles, mid-frame size requests
    task automatic t_stalls_bubbles();
        int start = nlog;
        hold_bad = 0;
        sink_mode = 1;
        send_frame(1, 16'h1000, 1, 1);
        send_frame(2, 16'h2000, 1, 1);
        send_frame(0, 16'h3000, 0, 1);
        up_end();
        wait_log(start + 16 + 32 + 8);
        check_frame(start, 1, 16'h1000, "R10");
        check_frame(start + 16, 2, 16'h2000, "R10");
        check_frame(start + 48, 0, 16'h3000, "R2");
        chk(hold_bad == 0, "R2", "outputs changed during stall", hold_bad, 0);
        sink_mode = 0;
    endtask

    // R7, R8: long drain on a size change
    task automatic t_drain();
        int start = nlog;
        sink_mode = 0;
        hold_bad = 0;
        saw_to = 0;
        send_frame(0, 16'h4000, 0, 0);
        drain_left = 300;
        sink_mode = 3;
        send_frame(2, 16'h5000, 0, 0);
        up_end();
        wait_log(start + 8 + 32);
        check_frame(start, 0, 16'h4000, "R7");
        check_frame(start + 8, 2, 16'h5000, "R7");
        chk(log_cyc[start+8] - log_cyc[start+7] == 302, "R7", "cycles eop to delayed sop",
            log_cyc[start+8] - log_cyc[start+7], 302);
        chk(hold_bad == 0, "R7", "start sample changed during drain", hold_bad, 0);
        chk(saw_to == 1, "R8", "timeout seen during long drain", int'(saw_to), 1);
        sink_mode = 0;
    endtask

    // R8: exact rise and fall of the watchdog flag
    task automatic t_timeout();
        int start = nlog;
        sink_mode = 2;
        fork
            send_frame(0, 16'h6000, 0, 0);
            begin
                do @(negedge clk); while (dn_valid !== 1'b1);
                repeat (TO - 1) @(negedge clk);
                chk(stall_timeout === 1'b0, "R8", "flag one cycle before limit",
                    int'(stall_timeout), 0);
                @(negedge clk);
                chk(stall_timeout === 1'b1, "R8", "flag at limit", int'(stall_timeout), 1);
                #1 sink_mode = 0;
                @(negedge clk);
                @(negedge clk);
                chk(stall_timeout === 1'b0, "R8", "flag after transfer", int'(stall_timeout), 0);
            end
        join
        up_end();
        wait_log(start + 8);
        check_frame(start, 0, 16'h6000, "R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected completion", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_all_sizes();
        t_stalls_bubbles();
        t_drain();
        t_timeout();
        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule